// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the setting of a frequency synthesizer: a 9-bit feedback divide value, a 3-bit output divide code and a 2-bit test selector. Values reach it over either of two paths. The first path is a set of parallel pins with an active-low strobe. While the strobe is low the pins flow straight into the active registers. The rising edge of the strobe freezes them.

The second path is a three-wire serial port made of a serial clock, a data line and a load strobe. Bits shift into a 14-bit staging register. A rising load strobe copies the staged word into the active registers, and a falling load strobe freezes them. While the load strobe is held high, every serial clock edge writes the freshly shifted word through to the active registers.

The serial and strobe inputs are asynchronous to the block. They pass through synchronizers on a fast system clock, and edges are found by comparing each sample with the one before it. The test selector routes one of four signals to an observation pin: constant low, the last serial bit, the feedback divider output or the output clock. That pin is held low in parallel mode and during master reset. A flag reports a feedback value outside the lockable range.

Top module: `synth_cfg_loader`

## Requirements
- R1: While the synchronized parallel strobe `par_ld_n` is low, `m_q` and `n_q` follow `m_pin` and `n_pin`, within a few system clocks.
- R2: Once `par_ld_n` has risen, changes on `m_pin` and `n_pin` have no effect on `m_q`, `n_q` or `t_q` until a serial event occurs or the strobe falls again.
- R3: With `par_ld_n` high, each rising `sclk` shifts `sdata` into the staging word. Bits arrive first-to-last as T1, T0, N2, N1, N0, M8 down to M0. Once staged, T occupies word bits 13:12, N bits 11:9 and M bits 8:0. Shifting while `sload` is low leaves the active registers unchanged.
- R4: A rising `sload` copies the staging word into `t_q`, `n_q` and `m_q`. After `sload` falls, further shifting leaves them unchanged.
- R5: While `sload` is high, every rising `sclk` loads the newly shifted staging word into the active registers.
- R6: With `par_ld_n` high and `mr` low, `test_o` follows the code `t_q`: 00 gives low, 01 gives the most recently shifted serial bit, 10 gives `mdiv_fb` and 11 gives `fout_clk`.
- R7: While `par_ld_n` is low, `test_o` is low and `t_q` does not change.
- R8: While `mr` is high, `test_o` is low and `m_q`, `n_q` and `t_q` keep their values.
- R9: `m_bad` is high exactly when `m_q` is below 125 or above 350.
- R10: Asserting `rst_n` low clears `m_q`, `n_q`, `t_q` and the staging word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the strobes |
| rst_n | input | 1 | Active-low reset of the block's registers |
| mr | input | 1 | Master reset; mutes the test pin and keeps the setting |
| par_ld_n | input | 1 | Parallel strobe: low is transparent, the rising edge latches |
| m_pin | input | 9 | Parallel feedback divide value |
| n_pin | input | 3 | Parallel output divide code |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data |
| sload | input | 1 | Serial load strobe |
| mdiv_fb | input | 1 | Feedback divider output, for observation |
| fout_clk | input | 1 | Output clock, for observation |
| m_q | output | 9 | Active feedback divide value |
| n_q | output | 3 | Active output divide code |
| t_q | output | 2 | Active test selector |
| m_bad | output | 1 | Feedback value outside 125..350 |
| test_o | output | 1 | Observation output |

## Verification
The assertions assume that `sclk`, `sload` and `par_ld_n` each stay level for several system clocks, so that every edge is seen once after synchronization. They also assume that `sdata` is steady around each rising `sclk`, and that a serial clock edge and a load strobe edge never reach the logic in the same cycle. The stimulus keeps each level for four system clocks and changes data only while `sclk` is low. It moves `sload` only between serial pulses, and it changes the parallel pins at falling system clock edges.

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader #(
  parameter int M_W   = 9,
  parameter int N_W   = 3,
  parameter int T_W   = 2,
  parameter int SYNC  = 2,
  parameter int M_MIN = 125,
  parameter int M_MAX = 350
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic           par_ld_n,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic           sclk,
  input  logic           sdata,
  input  logic           sload,
  input  logic           mdiv_fb,
  input  logic           fout_clk,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q,
  output logic           m_bad,
  output logic           test_o
);
  localparam int SR_W = T_W + N_W + M_W;

  logic [SYNC:0]   sclk_p, sload_p;
  logic [SYNC-1:0] par_p, sd_p;
  logic [SR_W-1:0] sr, sr_nxt;
  logic            par_s, sload_s, sd_s, sclk_rise, sload_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p  <= '0;
      sload_p <= '0;
      par_p   <= '1;
      sd_p    <= '0;
    end else begin
      sclk_p  <= {sclk_p[SYNC-1:0], sclk};
      sload_p <= {sload_p[SYNC-1:0], sload};
      par_p   <= {par_p[SYNC-2:0], par_ld_n};
      sd_p    <= {sd_p[SYNC-2:0], sdata};
    end
  end

  assign par_s      = par_p[SYNC-1];
  assign sload_s    = sload_p[SYNC-1];
  assign sd_s       = sd_p[SYNC-1];
  assign sclk_rise  = sclk_p[SYNC-1] & ~sclk_p[SYNC];
  assign sload_rise = sload_s & ~sload_p[SYNC];
  assign sr_nxt     = {sr[SR_W-2:0], sd_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sr <= '0;
    else if (par_s && sclk_rise) sr <= sr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (!par_s) begin
      m_q <= m_pin;
      n_q <= n_pin;
    end else if (sclk_rise && sload_s) begin
      {t_q, n_q, m_q} <= sr_nxt;
    end else if (sload_rise) begin
      {t_q, n_q, m_q} <= sr;
    end
  end

  assign m_bad  = (m_q < M_W'(M_MIN)) || (m_q > M_W'(M_MAX));
  assign test_o = (mr || !par_s)   ? 1'b0     :
                  (t_q == 2'b01)   ? sr[0]    :
                  (t_q == 2'b10)   ? mdiv_fb  :
                  (t_q == 2'b11)   ? fout_clk : 1'b0;
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk #(
  parameter int M_W  = 9,
  parameter int N_W  = 3,
  parameter int T_W  = 2,
  parameter int SR_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mr,
  input logic            par_s,
  input logic            sload_s,
  input logic            sclk_rise,
  input logic            sload_rise,
  input logic            sd_s,
  input logic [SR_W-1:0] sr,
  input logic [M_W-1:0]  m_pin,
  input logic [N_W-1:0]  n_pin,
  input logic [M_W-1:0]  m_q,
  input logic [N_W-1:0]  n_q,
  input logic [T_W-1:0]  t_q,
  input logic            test_o
);
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !par_s |=> (m_q == $past(m_pin) && n_q == $past(n_pin))); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (par_s && !sclk_rise && !sload_rise) |=> $stable({t_q, n_q, m_q})); // R2
  AST_LOAD_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (par_s && sload_rise && !sclk_rise) |=> ({t_q, n_q, m_q} == $past(sr))); // R4
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (par_s && sload_s && sclk_rise) |=> (m_q[0] == $past(sd_s))); // R5
  AST_TEST_OFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (par_s && t_q == '0) |-> !test_o); // R6
  AST_TEST_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mr || !par_s) |-> !test_o); // R7
  AST_T_KEEP_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    !par_s |=> $stable(t_q)); // R7
endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(
  .M_W(M_W), .N_W(N_W), .T_W(T_W), .SR_W(SR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mr(mr), .par_s(par_s), .sload_s(sload_s),
  .sclk_rise(sclk_rise), .sload_rise(sload_rise), .sd_s(sd_s), .sr(sr),
  .m_pin(m_pin), .n_pin(n_pin), .m_q(m_q), .n_q(n_q), .t_q(t_q),
  .test_o(test_o)
);

// File: tb/tb_synth_cfg_loader.sv
`timescale 1ns/1ps
module tb_synth_cfg_loader;
  logic clk = 1'b0, rst_n = 1'b0, mr = 1'b0, par_ld_n = 1'b1;
  logic [8:0] m_pin = '0;
  logic [2:0] n_pin = '0;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0, mdiv_fb = 1'b0, fout_clk = 1'b0;
  logic [8:0] m_q;
  logic [2:0] n_q;
  logic [1:0] t_q;
  logic m_bad, test_o;

  synth_cfg_loader dut (
    .clk(clk), .rst_n(rst_n), .mr(mr), .par_ld_n(par_ld_n), .m_pin(m_pin),
    .n_pin(n_pin), .sclk(sclk), .sdata(sdata), .sload(sload),
    .mdiv_fb(mdiv_fb), .fout_clk(fout_clk), .m_q(m_q), .n_q(n_q),
    .t_q(t_q), .m_bad(m_bad), .test_o(test_o)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    string      req;
    logic [8:0] m;
    logic [2:0] n;
    logic [1:0] t;
    logic       bad;
    logic       tst;
    bit         ck_tst;
  } item_t;

  item_t q[$];
  int total = 0, fails = 0;
  bit done = 1'b0;

  logic [8:0]  em = '0;
  logic [2:0]  en = '0;
  logic [1:0]  et = '0;
  logic [13:0] sr_m = '0;
  logic        last_bit = 1'b0;

  task automatic expect_item(string req, bit ck_tst, logic tst);
    item_t it;
    repeat (6) @(posedge clk);
    it.req = req; it.m = em; it.n = en; it.t = et;
    it.bad = (em < 9'd125) || (em > 9'd350);
    it.tst = tst; it.ck_tst = ck_tst;
    q.push_back(it);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (m_q !== it.m || n_q !== it.n || t_q !== it.t || m_bad !== it.bad ||
          (it.ck_tst && test_o !== it.tst)) begin
        fails++;
        $display("FAIL %s: m=%0d n=%0d t=%0d bad=%0b test=%0b expected m=%0d n=%0d t=%0d bad=%0b test=%0b",
                 it.req, m_q, n_q, t_q, m_bad, test_o, it.m, it.n, it.t, it.bad, it.tst);
      end
    end
  end

  task automatic par_set(logic strobe, logic [8:0] m, logic [2:0] n);
    @(negedge clk);
    par_ld_n = strobe; m_pin = m; n_pin = n;
    if (!strobe) begin em = m; en = n; end
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(logic b);
    @(negedge clk);
    sdata = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    if (par_ld_n) begin
      sr_m = {sr_m[12:0], b};
      last_bit = b;
      if (sload) {et, en, em} = sr_m;
    end
  endtask

  task automatic set_sload(logic v);
    @(negedge clk);
    if (v && !sload && par_ld_n) {et, en, em} = sr_m;
    sload = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic shift_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) pulse(w[i]);
  endtask

  task automatic serial_load(logic [13:0] w);
    shift_word(w);
    set_sload(1'b1);
    set_sload(1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    expect_item("R10 reset clears settings", 1'b1, 1'b0);

    par_set(1'b0, 9'd200, 3'd5);
    expect_item("R1 transparent load", 1'b1, 1'b0);
    par_set(1'b0, 9'd300, 3'd2);
    expect_item("R1 follows pin change", 1'b1, 1'b0);
    par_set(1'b1, 9'd300, 3'd2);
    par_set(1'b1, 9'd126, 3'd7);
    expect_item("R2 pins ignored after latch", 1'b0, 1'b0);

    par_set(1'b0, 9'd124, 3'd0); expect_item("R9 below range", 1'b0, 1'b0);
    par_set(1'b0, 9'd125, 3'd0); expect_item("R9 lower bound", 1'b0, 1'b0);
    par_set(1'b0, 9'd350, 3'd0); expect_item("R9 upper bound", 1'b0, 1'b0);
    par_set(1'b0, 9'd351, 3'd0); expect_item("R9 above range", 1'b0, 1'b0);
    par_set(1'b0, 9'd180, 3'd1);
    par_set(1'b1, 9'd180, 3'd1);

    shift_word({2'b01, 3'd3, 9'd260});
    expect_item("R3 shifting keeps active values", 1'b1, 1'b0);
    set_sload(1'b1);
    expect_item("R4 rising load transfers", 1'b1, 1'b0);
    set_sload(1'b0);
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    expect_item("R4 frozen after falling load", 1'b1, 1'b0);
    pulse(1'b1);
    expect_item("R6 code 01 shows last serial bit", 1'b1, 1'b1);

    set_sload(1'b1);
    expect_item("R5 rising load before pass-through", 1'b0, 1'b0);
    for (int i = 13; i >= 0; i--) begin
      logic [13:0] w;
      w = {2'b10, 3'd4, 9'd125};
      pulse(w[i]);
      expect_item("R5 pass-through on each serial clock", 1'b0, 1'b0);
    end
    set_sload(1'b0);

    @(negedge clk) mdiv_fb = 1'b1;
    expect_item("R6 code 10 shows feedback high", 1'b1, 1'b1);
    @(negedge clk) mdiv_fb = 1'b0;
    expect_item("R6 code 10 shows feedback low", 1'b1, 1'b0);

    serial_load({2'b11, 3'd0, 9'd349});
    @(negedge clk) fout_clk = 1'b1;
    expect_item("R6 code 11 shows output clock", 1'b1, 1'b1);

    @(negedge clk) mr = 1'b1;
    expect_item("R8 master reset mutes test and keeps settings", 1'b1, 1'b0);
    @(negedge clk) mr = 1'b0;
    expect_item("R8 test returns after master reset", 1'b1, 1'b1);

    par_set(1'b0, 9'd222, 3'd6);
    expect_item("R7 parallel mode mutes test and keeps T", 1'b1, 1'b0);
    par_set(1'b1, 9'd222, 3'd6);
    expect_item("R7 test returns in serial mode", 1'b1, 1'b1);

    serial_load({2'b00, 3'd5, 9'd333});
    @(negedge clk) begin mdiv_fb = 1'b1; fout_clk = 1'b1; end
    expect_item("R6 code 00 holds test low", 1'b1, 1'b0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule